// File: doc/BRIEF.md
# Bus Master Activity Controller

This block decides when a processor that shares an external bus may drive it. It takes an asynchronous active-low grant from an outside arbiter, an access-in-progress flag from the processor's bus sequencer and a software bus-lock bit. From these it produces the bus-master active indication `act`, output enables for the address and data buses, and a set of enables and drive-high requests for the control-line pad drivers.

Mastership begins a few cycles after the grant is seen, because the grant passes through a synchroniser. Once held, mastership lasts while the grant stays, while a bus access is still running, and, when the lock bit is cleared to 0 and an access has taken place since then, until software sets the bit back to 1. When mastership ends, the address and data enables are removed at once. The control lines are driven high for exactly one cycle and then floated. A grant that shows up during that drive-high cycle only takes effect once the cycle has ended.

Top module: `bus_master_act`

## Requirements
- R1: While reset is asserted and after it is released with no grant, `act`, `addr_oe`, `data_oe`, every bit of `ctrl_oe` and every bit of `ctrl_drive_hi` are 0.
- R2: With the controller idle, a `grant_n` that goes low half a cycle before a rising edge makes `act` go high on the third rising edge from that point, and not before. This latency comes from a two-flop synchroniser and one registered stage.
- R3: `addr_oe` and `data_oe` equal `act` in every cycle. They are removed in the same cycle that `act` falls.
- R4: While `act` is 1 and `access_busy` is 1, `act` stays 1 on the next edge whatever `grant_n` does. When the access ends with the grant already gone and no lock held, `act` falls on the next rising edge.
- R5: When `bus_lock_n` is 0 and an access (`access_busy`=1 while `act`=1) has taken place, `act` stays 1 after the grant is removed, until `bus_lock_n` returns to 1. `act` then falls on the next rising edge if no access is running. Clearing `bus_lock_n` with no access in between does not hold `act`.
- R6: In the cycle after `act` falls, every bit of `ctrl_oe` and every bit of `ctrl_drive_hi` is 1. In the cycle after that, all of them are 0.
- R7: Whenever `act` is 1, every bit of `ctrl_oe` is 1 and every bit of `ctrl_drive_hi` is 0.
- R8: A grant that arrives while the drive-high cycle is running is not honoured until that cycle has ended. `act` never rises in a cycle directly after one in which `ctrl_oe` was asserted.
- R9: With no access and no lock held, a `grant_n` that goes high half a cycle before a rising edge makes `act` fall on the third rising edge from that point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| grant_n | input | 1 | Asynchronous bus grant, active low |
| access_busy | input | 1 | A bus access is in progress |
| bus_lock_n | input | 1 | Software bus-lock bit; 0 requests the lock |
| act | output | 1 | Bus-master active indication |
| addr_oe | output | 1 | Address bus output enable |
| data_oe | output | 1 | Data bus output enable |
| ctrl_oe | output | CTRL_LINES (4) | Per-line control driver enable |
| ctrl_drive_hi | output | CTRL_LINES (4) | Per-line request to force the control line high |

## Verification
The hardest case to reach from the ports is a grant that comes back exactly in the single drive-high cycle. Because of the synchroniser, that means raising `grant_n` and lowering it again one cycle later, so that the synchronised low arrives just as the release cycle starts. A directed sequence builds this case with exact timing. The lock hold is also directed: the lock bit is cleared, one access is pulsed, the grant is removed, and the bench then waits before setting the bit again. The random phase toggles grant, access and lock against a cycle-level reference model and reaches the same corners with many more phase offsets.

// File: rtl/act_ctl_pkg.sv
package act_ctl_pkg;

  typedef enum logic [1:0] {
    OWN_IDLE    = 2'b00,
    OWN_ACTIVE  = 2'b01,
    OWN_RELEASE = 2'b10
  } own_state_e;

endpackage

// File: rtl/act_ctl_sync.sv
module act_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic grant_n,
  output logic rst_sync_n,
  output logic granted
);

  localparam int LAST = STAGES - 1;

  logic [1:0]      rst_pipe_q;
  logic [LAST:0]   gnt_pipe_q;

  // Reset asserts at once and is released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe_q[1];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_sync_n) begin
          if (!rst_sync_n) begin
            gnt_pipe_q[0] <= 1'b0;
          end else begin
            gnt_pipe_q[0] <= ~grant_n;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_sync_n) begin
          if (!rst_sync_n) begin
            gnt_pipe_q[i] <= 1'b0;
          end else begin
            gnt_pipe_q[i] <= gnt_pipe_q[i-1];
          end
        end
      end
    end
  endgenerate

  assign granted = gnt_pipe_q[LAST];

endmodule

// File: rtl/act_ctl_lock.sv
module act_ctl_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic owning,
  input  logic access_busy,
  input  logic bus_lock_n,
  output logic lock_hold
);

  logic armed_q;
  logic armed_d;
  logic armed_en;

  // Arming needs an access under the lock; setting the bit disarms.
  always_comb begin
    armed_en = 1'b0;
    armed_d  = armed_q;
    if (bus_lock_n) begin
      armed_en = armed_q;
      armed_d  = 1'b0;
    end else if (owning && access_busy && !armed_q) begin
      armed_en = 1'b1;
      armed_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_en) begin
      armed_q <= armed_d;
    end
  end

  // The bit is looked at directly so that setting it frees the bus on the next edge.
  assign lock_hold = armed_q & ~bus_lock_n;

endmodule

// File: rtl/act_ctl_fsm.sv
module act_ctl_fsm
  import act_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       granted,
  input  logic       access_busy,
  input  logic       lock_hold,
  output own_state_e state
);

  own_state_e state_q;
  own_state_e state_d;
  logic       keep;

  always_comb begin
    keep    = granted | access_busy | lock_hold;
    state_d = state_q;
    unique case (state_q)
      OWN_IDLE:    if (granted) state_d = OWN_ACTIVE;
      OWN_ACTIVE:  if (!keep)   state_d = OWN_RELEASE;
      OWN_RELEASE:              state_d = OWN_IDLE;
      default:                  state_d = OWN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= OWN_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign state = state_q;

endmodule

// File: rtl/act_ctl_drive.sv
module act_ctl_drive
  import act_ctl_pkg::*;
#(
  parameter int CTRL_LINES = 4
) (
  input  own_state_e            state,
  output logic                  act,
  output logic                  addr_oe,
  output logic                  data_oe,
  output logic [CTRL_LINES-1:0] ctrl_oe,
  output logic [CTRL_LINES-1:0] ctrl_drive_hi
);

  logic owning;
  logic releasing;

  assign owning    = (state == OWN_ACTIVE);
  assign releasing = (state == OWN_RELEASE);

  assign act     = owning;
  assign addr_oe = owning;
  assign data_oe = owning;

  generate
    for (genvar k = 0; k < CTRL_LINES; k++) begin : g_line
      assign ctrl_oe[k]       = owning | releasing;
      assign ctrl_drive_hi[k] = releasing;
    end
  endgenerate

endmodule

// File: rtl/bus_master_act.sv
module bus_master_act
  import act_ctl_pkg::*;
#(
  parameter int CTRL_LINES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  grant_n,
  input  logic                  access_busy,
  input  logic                  bus_lock_n,
  output logic                  act,
  output logic                  addr_oe,
  output logic                  data_oe,
  output logic [CTRL_LINES-1:0] ctrl_oe,
  output logic [CTRL_LINES-1:0] ctrl_drive_hi
);

  logic       rst_sync_n;
  logic       granted;
  logic       lock_hold;
  logic       owning;
  logic       busy_own;
  own_state_e state;

  act_ctl_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_n    (grant_n),
    .rst_sync_n (rst_sync_n),
    .granted    (granted)
  );

  assign owning   = (state == OWN_ACTIVE);
  assign busy_own = access_busy & owning;

  act_ctl_lock i_lock (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .owning      (owning),
    .access_busy (access_busy),
    .bus_lock_n  (bus_lock_n),
    .lock_hold   (lock_hold)
  );

  act_ctl_fsm i_fsm (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .granted     (granted),
    .access_busy (busy_own),
    .lock_hold   (lock_hold),
    .state       (state)
  );

  act_ctl_drive #(.CTRL_LINES(CTRL_LINES)) i_drive (
    .state         (state),
    .act           (act),
    .addr_oe       (addr_oe),
    .data_oe       (data_oe),
    .ctrl_oe       (ctrl_oe),
    .ctrl_drive_hi (ctrl_drive_hi)
  );

endmodule

// File: rtl/bus_master_act_chk.sv
module bus_master_act_chk #(
  parameter int CTRL_LINES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  access_busy,
  input logic                  act,
  input logic                  addr_oe,
  input logic                  data_oe,
  input logic [CTRL_LINES-1:0] ctrl_oe,
  input logic [CTRL_LINES-1:0] ctrl_drive_hi
);

  // R3
  enables_follow_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe == act) && (data_oe == act));

  // R7
  ctrl_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> ((&ctrl_oe) && (ctrl_drive_hi == '0)));

  // R6
  release_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> ((&ctrl_oe) && (&ctrl_drive_hi)));

  // R6
  release_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_drive_hi != '0) |=> ((ctrl_drive_hi == '0) && (ctrl_oe == '0) && !act));

  // R4
  access_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && access_busy) |=> act);

  // R8
  no_regrant_in_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> ($past(ctrl_oe) == '0));

endmodule

bind bus_master_act bus_master_act_chk #(.CTRL_LINES(CTRL_LINES)) i_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .access_busy   (access_busy),
  .act           (act),
  .addr_oe       (addr_oe),
  .data_oe       (data_oe),
  .ctrl_oe       (ctrl_oe),
  .ctrl_drive_hi (ctrl_drive_hi)
);

// File: tb/test_bus_master_act.sv
`timescale 1ns/1ps
module test_bus_master_act;

  localparam int NL = 4;

  logic          clk;
  logic          rst_n;
  logic          grant_n;
  logic          access_busy;
  logic          bus_lock_n;
  logic          act;
  logic          addr_oe;
  logic          data_oe;
  logic [NL-1:0] ctrl_oe;
  logic [NL-1:0] ctrl_drive_hi;

  int n_chk;
  int n_fail;
  bit done;

  // Reference model state: 0 idle, 1 active, 2 release
  int m_st;
  bit m_g1, m_g2, m_armed;

  bus_master_act #(.CTRL_LINES(NL)) i_bus_master_act (
    .clk           (clk),
    .rst_n         (rst_n),
    .grant_n       (grant_n),
    .access_busy   (access_busy),
    .bus_lock_n    (bus_lock_n),
    .act           (act),
    .addr_oe       (addr_oe),
    .data_oe       (data_oe),
    .ctrl_oe       (ctrl_oe),
    .ctrl_drive_hi (ctrl_drive_hi)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit exp_act();
    return m_st == 1;
  endfunction

  function automatic logic [NL-1:0] exp_oe();
    return (m_st != 0) ? '1 : '0;
  endfunction

  function automatic logic [NL-1:0] exp_hi();
    return (m_st == 2) ? '1 : '0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, got, exp, $time);
    end
  endtask

  // Compare every output with the model
  task automatic cmp_all();
    chk("R2/R4/R5/R9", "act", 32'(act), 32'(exp_act()));
    chk("R3", "addr_oe", 32'(addr_oe), 32'(exp_act()));
    chk("R3", "data_oe", 32'(data_oe), 32'(exp_act()));
    chk("R6/R7", "ctrl_oe", 32'(ctrl_oe), 32'(exp_oe()));
    chk("R6/R7", "ctrl_drive_hi", 32'(ctrl_drive_hi), 32'(exp_hi()));
  endtask

  // Inputs are stable from the previous negedge; advance one cycle.
  task automatic step();
    bit keep;
    int nst;
    @(posedge clk);
    keep = m_g2 || (m_st == 1 && access_busy) || (m_armed && !bus_lock_n);
    case (m_st)
      0:       nst = m_g2 ? 1 : 0;
      1:       nst = keep ? 1 : 2;
      default: nst = 0;
    endcase
    if (bus_lock_n) m_armed = 1'b0;
    else if (m_st == 1 && access_busy) m_armed = 1'b1;
    m_g2 = m_g1;
    m_g1 = ~grant_n;
    m_st = nst;
    @(negedge clk);
    cmp_all();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    n_chk = 0; n_fail = 0; done = 0;
    m_st = 0; m_g1 = 0; m_g2 = 0; m_armed = 0;
    rst_n = 1'b0; grant_n = 1'b0; access_busy = 1'b0; bus_lock_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs quiet while reset is held, even with grant low
    chk("R1", "act in reset", 32'(act), 32'd0);
    chk("R1", "ctrl_oe in reset", 32'(ctrl_oe), 32'd0);
    chk("R1", "ctrl_drive_hi in reset", 32'(ctrl_drive_hi), 32'd0);
    chk("R1", "addr_oe in reset", 32'(addr_oe), 32'd0);
    grant_n = 1'b1;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    m_g1 = 1'b0; m_g2 = 1'b0;
    cmp_all();

    // R2: grant latency
    grant_n = 1'b0;
    step(); chk("R2", "act after edge 1", 32'(act), 32'd0);
    step(); chk("R2", "act after edge 2", 32'(act), 32'd0);
    step(); chk("R2", "act after edge 3", 32'(act), 32'd1);
    chk("R7", "ctrl_oe while active", 32'(ctrl_oe), 32'hF);
    steps(2);

    // R9 and R6: release sequence
    grant_n = 1'b1;
    steps(2); chk("R9", "act still held", 32'(act), 32'd1);
    step();   chk("R9", "act fell", 32'(act), 32'd0);
    chk("R6", "drive high cycle", 32'(ctrl_drive_hi), 32'hF);
    chk("R6", "ctrl_oe in drive high", 32'(ctrl_oe), 32'hF);
    chk("R3", "addr_oe off at fall", 32'(addr_oe), 32'd0);
    step();
    chk("R6", "drive high ended", 32'(ctrl_drive_hi), 32'h0);
    chk("R6", "ctrl floated", 32'(ctrl_oe), 32'h0);
    steps(2);

    // R4: hold through access
    grant_n = 1'b0; steps(4);
    access_busy = 1'b1; grant_n = 1'b1; steps(6);
    chk("R4", "act held by access", 32'(act), 32'd1);
    access_busy = 1'b0; step();
    chk("R4", "act fell after access", 32'(act), 32'd0);
    steps(3);

    // R5: lock held after an access
    grant_n = 1'b0; steps(4);
    bus_lock_n = 1'b0; step();
    access_busy = 1'b1; step();
    access_busy = 1'b0; grant_n = 1'b1; steps(8);
    chk("R5", "act held by lock", 32'(act), 32'd1);
    bus_lock_n = 1'b1; step();
    chk("R5", "act fell on lock release", 32'(act), 32'd0);
    steps(3);

    // R5: lock cleared without any access does not hold
    grant_n = 1'b0; steps(4);
    bus_lock_n = 1'b0; grant_n = 1'b1; steps(3);
    chk("R5", "no access, no hold", 32'(act), 32'd0);
    bus_lock_n = 1'b1; steps(3);

    // R8: grant returns right in the drive-high cycle
    grant_n = 1'b0; steps(4);
    grant_n = 1'b1; step();
    grant_n = 1'b0; step(); step();
    chk("R8", "act fell", 32'(act), 32'd0);
    chk("R8", "drive high running", 32'(ctrl_drive_hi), 32'hF);
    step();
    chk("R8", "no act right after release", 32'(act), 32'd0);
    chk("R8", "ctrl floated before regrant", 32'(ctrl_oe), 32'h0);
    step();
    chk("R8", "regrant honoured", 32'(act), 32'd1);
    steps(2);

    // Random phase
    for (int c = 0; c < 20000; c++) begin
      if ($urandom_range(7) == 0) grant_n = ~grant_n;
      access_busy = exp_act() ? 1'($urandom_range(1)) : 1'b0;
      if ($urandom_range(31) == 0) bus_lock_n = ~bus_lock_n;
      step();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule